// File: doc/BRIEF.md
# Time-Aware Gate Schedule Sequencer

This block walks a list of gate-control commands held in a small local command memory. Each 22-bit command pairs a duration, counted in clock ticks, with an 8-bit mask of the priority queues that may transmit while the command is in force. The block drives that mask onto its gate output for exactly the programmed duration, then moves to the next command. An external cycle-start pulse restarts the list at its first entry, so the schedule repeats with the period of the pulse generator.

The command memory has two modes. In split mode it forms two 64-entry banks. One bank is operational and is being walked. The other is administrative and can be rewritten by software without disturbing the running schedule. A software swap request makes the administrative bank operational, but only at the next cycle start. In single mode the whole 128-entry memory holds one long list. Software loads entries and a per-bank command count through a simple write port. A global enable, when low, opens every gate.

Top module: `gate_sched_seq`

## Requirements
- R1: After reset, gate_mask is all ones, oper_bank is 0 and swap_done is 0.
- R2: A command word carries the duration in bits 21:8 and the gate mask in bits 7:0, where mask bit i opens priority queue i.
- R3: A cycle_start sampled at a clock edge puts entry 0's mask on gate_mask from that edge. Each command with a nonzero duration N holds its mask for exactly N clock cycles, and the next command follows with no gap.
- R4: Once the last counted command has expired, gate_mask keeps that command's mask until the next cycle_start.
- R5: A cycle_start that arrives while the list is still running abandons the remaining commands and restarts the walk at entry 0.
- R6: A command with duration 0 is skipped: its mask never appears, and the previous mask stays on gate_mask for one extra clock cycle.
- R7: While cfg_enable is 0, gate_mask reads all ones. The walk keeps advancing underneath, so raising cfg_enable shows the mask of the command currently in force.
- R8: In split mode (cfg_single = 0), bank b occupies memory addresses b*64 to b*64+63. The walk uses the operational bank and that bank's command count, and any count above 64 is treated as 64.
- R9: A swap_req pulse is held pending and takes effect only at the next cycle_start. At that edge oper_bank toggles, swap_done is 1 for exactly one cycle, and the new bank's entry 0 drives gate_mask. Writes to the administrative bank never change the schedule being walked.
- R10: In single mode (cfg_single = 1), the walk covers addresses 0 to 127 from address 0, using the count of bank 0 capped at 128. A swap_req in this mode is ignored.
- R11: A swap_req in the same cycle as cycle_start takes effect at that cycle_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wire-side clock; one tick of duration per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | 1 = apply schedule, 0 = all gates open |
| cfg_single | input | 1 | 1 = one 128-entry list, 0 = two 64-entry banks |
| wr_en | input | 1 | Command write strobe |
| wr_addr | input | 7 | Command memory address |
| wr_data | input | 22 | Command word {duration[13:0], mask[7:0]} |
| cnt_en | input | 1 | Command-count write strobe |
| cnt_bank | input | 1 | Bank whose count is written |
| cnt_val | input | 8 | Number of commands in the bank's list |
| swap_req | input | 1 | Request to make the administrative bank operational |
| cycle_start | input | 1 | Restart the list at entry 0 |
| gate_mask | output | 8 | Per-priority transmit gates, bit i = queue i |
| oper_bank | output | 1 | Index of the operational bank |
| swap_done | output | 1 | One-cycle flag marking a completed bank swap |

## Verification
The bench expands each programmed list into a tick-by-tick expected mask and compares it every cycle. It targets the following failure modes:
- An off-by-one duration counter would shift every later transition by one tick.
- A mishandled zero-duration entry would either flash its mask or swallow a tick.
- A missing end-of-list hold would show a stale or open mask.
- It checks that a restart in mid-list really begins again at entry 0.
- It checks that a swap never occurs before the cycle boundary, and that a write to the idle bank leaves the running schedule untouched.
- For single mode, it walks across the 64-entry seam.
- It checks that the split-mode count is capped at 64, and that a swap request arriving together with the cycle start is applied at once rather than one cycle late.

// File: rtl/gsq_pkg.sv
package gsq_pkg;
    localparam int PRIO_N     = 8;
    localparam int DUR_W      = 14;
    localparam int WORD_W     = DUR_W + PRIO_N;
    localparam int RAM_DEPTH  = 128;
    localparam int NBANK      = 2;
    localparam int HALF_DEPTH = RAM_DEPTH / NBANK;
    localparam int ADDR_W     = $clog2(RAM_DEPTH);
    localparam int PTR_W      = ADDR_W + 1;
    localparam int CNT_W      = PTR_W;

    typedef struct packed {
        logic [DUR_W-1:0]  dur;
        logic [PRIO_N-1:0] gates;
    } cmd_t;
endpackage

// File: rtl/gsq_store.sv
module gsq_store
    import gsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              cnt_en,
    input  logic              cnt_bank,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [ADDR_W-1:0] rd_addr,
    output cmd_t              rd_cmd,
    output logic [CNT_W-1:0]  cnt0,
    output logic [CNT_W-1:0]  cnt1
);
    typedef struct packed {
        logic [NBANK-1:0][CNT_W-1:0] cnt;
    } st_t;

    logic [WORD_W-1:0] mem_q [RAM_DEPTH];
    st_t st_d, st_q;

    // command memory: plain write port, asynchronous read for the walker
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NBANK; b++) begin
            if (cnt_en && (int'(cnt_bank) == b)) st_d.cnt[b] = cnt_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_cmd = cmd_t'(mem_q[rd_addr]);
    assign cnt0   = st_q.cnt[0];
    assign cnt1   = st_q.cnt[1];

    // count register only changes on a count write
    p_cnt_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(st_q.cnt));
endmodule

// File: rtl/gsq_bank.sv
module gsq_bank
    import gsq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic single_mode,
    input  logic swap_req,
    input  logic cycle_start,
    output logic oper_now,
    output logic oper_q,
    output logic swap_flag
);
    typedef struct packed {
        logic oper;
        logic pend;
        logic flag;
    } st_t;

    st_t st_d, st_q;
    logic pend_now;
    logic do_swap;

    always_comb begin
        st_d     = st_q;
        pend_now = st_q.pend | (swap_req & ~single_mode);
        do_swap  = cycle_start & pend_now & ~single_mode;
        st_d.oper = st_q.oper ^ do_swap;
        st_d.pend = do_swap ? 1'b0 : pend_now;
        st_d.flag = do_swap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oper_now  = st_d.oper;
    assign oper_q    = st_q.oper;
    assign swap_flag = st_q.flag;

    p_swap_at_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.oper) |-> $past(cycle_start));
    p_flag_marks_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flag |-> (!$stable(st_q.oper) && $past(cycle_start)));
    p_single_no_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (single_mode && $past(single_mode)) |-> $stable(st_q.oper));
endmodule

// File: rtl/gsq_walker.sv
module gsq_walker
    import gsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cycle_start,
    input  logic              single_mode,
    input  logic              bank_now,
    input  logic [CNT_W-1:0]  cnt0,
    input  logic [CNT_W-1:0]  cnt1,
    input  cmd_t              rd_cmd,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PRIO_N-1:0] gates
);
    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [DUR_W-1:0]  left;
        logic [PRIO_N-1:0] gates;
        logic              active;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] raw_cnt;
    logic [PTR_W-1:0] cap;
    logic [PTR_W-1:0] lim;
    logic [PTR_W-1:0] fetch_ptr;
    logic             need_fetch;

    always_comb begin
        raw_cnt = (single_mode || !bank_now) ? cnt0 : cnt1;
        cap     = single_mode ? PTR_W'(RAM_DEPTH) : PTR_W'(HALF_DEPTH);
        lim     = (PTR_W'(raw_cnt) > cap) ? cap : PTR_W'(raw_cnt);

        fetch_ptr  = cycle_start ? '0 : st_q.ptr;
        need_fetch = cycle_start || (st_q.active && (st_q.left <= DUR_W'(1)));

        if (single_mode) rd_addr = fetch_ptr[ADDR_W-1:0];
        else             rd_addr = {bank_now, fetch_ptr[ADDR_W-2:0]};

        st_d = st_q;
        if (need_fetch) begin
            if (fetch_ptr < lim) begin
                st_d.active = 1'b1;
                st_d.ptr    = fetch_ptr + PTR_W'(1);
                st_d.left   = rd_cmd.dur;
                if (rd_cmd.dur != '0) st_d.gates = rd_cmd.gates;
            end else begin
                st_d.active = 1'b0;
                st_d.left   = '0;
            end
        end else if (st_q.active) begin
            st_d.left = st_q.left - DUR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.gates <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign gates = st_q.gates;

    p_left_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.left > DUR_W'(1) && !cycle_start)
        |=> (st_q.left == $past(st_q.left) - DUR_W'(1)));
    p_mask_only_on_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.gates) |-> ($past(cycle_start) || $past(st_q.left) <= DUR_W'(1)));
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !cycle_start) |=> $stable(st_q.gates));
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> (st_q.ptr <= PTR_W'(1)));
    p_ptr_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ptr <= PTR_W'(RAM_DEPTH));
endmodule

// File: rtl/gate_sched_seq.sv
module gate_sched_seq
    import gsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_single,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              cnt_en,
    input  logic              cnt_bank,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              swap_req,
    input  logic              cycle_start,
    output logic [PRIO_N-1:0] gate_mask,
    output logic              oper_bank,
    output logic              swap_done
);
    cmd_t              rd_cmd;
    logic [ADDR_W-1:0] rd_addr;
    logic [CNT_W-1:0]  cnt0, cnt1;
    logic              oper_now;
    logic [PRIO_N-1:0] sched_gates;

    gsq_store u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_en(cnt_en), .cnt_bank(cnt_bank), .cnt_val(cnt_val),
        .rd_addr(rd_addr), .rd_cmd(rd_cmd), .cnt0(cnt0), .cnt1(cnt1)
    );

    gsq_bank u_bank (
        .clk(clk), .rst_n(rst_n), .single_mode(cfg_single),
        .swap_req(swap_req), .cycle_start(cycle_start),
        .oper_now(oper_now), .oper_q(oper_bank), .swap_flag(swap_done)
    );

    gsq_walker u_walk (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
        .single_mode(cfg_single), .bank_now(oper_now),
        .cnt0(cnt0), .cnt1(cnt1), .rd_cmd(rd_cmd),
        .rd_addr(rd_addr), .gates(sched_gates)
    );

    assign gate_mask = cfg_enable ? sched_gates : '1;
endmodule

// File: tb/sim_gate_sched_seq.sv
`timescale 1ns/1ps
module sim_gate_sched_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1, cfg_single = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [21:0] wr_data = '0;
    logic        cnt_en = 1'b0, cnt_bank = 1'b0;
    logic [7:0]  cnt_val = '0;
    logic        swap_req = 1'b0, cycle_start = 1'b0;
    logic [7:0]  gate_mask;
    logic        oper_bank, swap_done;

    int checks = 0;
    int failures = 0;
    logic [13:0] e_dur [128];
    logic [7:0]  e_msk [128];

    // table of {duration, mask} vectors for the main walk
    localparam logic [21:0] TBL [8] = '{
        {14'd3, 8'h01}, {14'd1, 8'h80}, {14'd0, 8'h55}, {14'd4, 8'h3C},
        {14'd2, 8'hA5}, {14'd1, 8'h00}, {14'd5, 8'hFF}, {14'd2, 8'h42}};

    always #4 clk = ~clk;

    gate_sched_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_single(cfg_single),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_en(cnt_en), .cnt_bank(cnt_bank), .cnt_val(cnt_val),
        .swap_req(swap_req), .cycle_start(cycle_start),
        .gate_mask(gate_mask), .oper_bank(oper_bank), .swap_done(swap_done));

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_cmd(int addr, int dur, logic [7:0] m);
        wr_en = 1'b1; wr_addr = 7'(addr); wr_data = {14'(dur), m};
        tick();
        wr_en = 1'b0;
    endtask

    task automatic put_cnt(logic b, int n);
        cnt_en = 1'b1; cnt_bank = b; cnt_val = 8'(n);
        tick();
        cnt_en = 1'b0;
    endtask

    task automatic pulse_start();
        cycle_start = 1'b1;
        tick();
        cycle_start = 1'b0;
    endtask

    // expand e_dur/e_msk into one expected mask per tick; first tick is now
    task automatic check_run(int n, logic [7:0] prev, int extra, string tag);
        logic [7:0] p = prev;
        bit first = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (e_dur[i] == 0) begin
                if (!first) tick();
                first = 1'b0;
                chk(32'(gate_mask), 32'(p), {tag, " R6 zero entry"});
            end else begin
                for (int k = 0; k < int'(e_dur[i]); k++) begin
                    if (!first) tick();
                    first = 1'b0;
                    chk(32'(gate_mask), 32'(e_msk[i]), tag);
                end
                p = e_msk[i];
            end
        end
        for (int e = 0; e < extra; e++) begin
            tick();
            chk(32'(gate_mask), 32'(p), {tag, " R4 hold"});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk(32'(gate_mask), 32'hFF, "R1 mask");
        chk(32'(oper_bank), 0, "R1 oper");
        chk(32'(swap_done), 0, "R1 swap_done");
        rst_n = 1'b1;
        tick();

        // R2 R3 R4 R6: table walked by one loop, bank 0
        for (int i = 0; i < 8; i++) begin
            put_cmd(i, int'(TBL[i][21:8]), TBL[i][7:0]);
            e_dur[i] = TBL[i][21:8];
            e_msk[i] = TBL[i][7:0];
        end
        put_cnt(1'b0, 8);
        pulse_start();
        check_run(8, 8'hFF, 3, "R2 R3 table");

        // R5 restart in mid-list
        pulse_start();
        tick(); tick();
        pulse_start();
        check_run(8, 8'h01, 1, "R5 restart");

        // R7 enable low forces open gates; walk continues underneath
        cfg_enable = 1'b0;
        pulse_start();
        for (int t = 0; t < 4; t++) begin
            if (t != 0) tick();
            chk(32'(gate_mask), 32'hFF, "R7 disabled");
        end
        tick();
        cfg_enable = 1'b1;
        #1;
        chk(32'(gate_mask), 32'h80, "R7 walk continued");

        // R8 R9: load bank 1, request swap, it waits for cycle_start
        put_cmd(64, 2, 8'h11);
        put_cmd(65, 3, 8'h22);
        put_cnt(1'b1, 2);
        swap_req = 1'b1; tick(); swap_req = 1'b0;
        tick(); tick();
        chk(32'(oper_bank), 0, "R9 no early swap");
        chk(32'(swap_done), 0, "R9 no early flag");
        pulse_start();
        chk(32'(oper_bank), 1, "R9 oper toggled");
        chk(32'(swap_done), 1, "R9 swap_done set");
        e_dur[0] = 14'd2; e_msk[0] = 8'h11;
        e_dur[1] = 14'd3; e_msk[1] = 8'h22;
        check_run(2, 8'h00, 2, "R8 R9 bank1 walk");
        chk(32'(swap_done), 0, "R9 swap_done one cycle");

        // R9 admin-bank write leaves running schedule alone
        put_cmd(0, 4, 8'h99);
        put_cnt(1'b0, 1);
        pulse_start();
        chk(32'(gate_mask), 32'h11, "R9 admin write isolated");
        chk(32'(oper_bank), 1, "R9 oper kept");

        // R10 single mode across the 64-entry seam; swap_req ignored
        cfg_single = 1'b1;
        for (int i = 0; i < 66; i++) begin
            put_cmd(i, 1, 8'(i));
            e_dur[i] = 14'd1;
            e_msk[i] = 8'(i);
        end
        put_cnt(1'b0, 66);
        swap_req = 1'b1;
        pulse_start();
        swap_req = 1'b0;
        chk(32'(oper_bank), 1, "R10 swap ignored");
        chk(32'(swap_done), 0, "R10 no flag");
        check_run(66, 8'h00, 2, "R10 single walk");

        // R11 swap with cycle_start same cycle; R8 count capped at 64
        cfg_single = 1'b0;
        tick();
        swap_req = 1'b1;
        pulse_start();
        swap_req = 1'b0;
        chk(32'(oper_bank), 0, "R11 immediate swap");
        chk(32'(swap_done), 1, "R11 flag");
        check_run(64, 8'h00, 3, "R8 R11 capped walk");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule